// File: doc/BRIEF.md
# Serial bus slave address recognizer

This block decides whether the first byte of a two-wire serial bus transfer is meant for this node. A host writes an 8-bit configuration word. Its upper seven bits are the node's own slave address. Its lowest bit allows the node to answer the all-zero general-call byte. The surrounding bus logic tells the block when a START (or repeated START) and a STOP have been seen. It also presents each received byte together with a completion strobe.

Only the first byte after a START is examined. If that byte carries the own address, or is the general-call byte while that answer is enabled, the block sets a sticky match flag and raises a one-cycle interrupt request. On an own-address match it also reports the direction bit of the byte. The flags stay set until the host clears them or a STOP arrives. The same address serves whether the node then acts as a slave transmitter or as a slave receiver.

Top module: `slvadr_match`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the configuration word to 00H and drives own_hit, gc_hit, rw_bit and irq to 0.
- R2: When cfg_we is high at a rising edge, cfg_wdata is stored, and it appears on cfg_rdata after that edge. Bits 7:1 are the own address and bit 0 is the general-call enable.
- R3: When byte_done strobes the first byte after a START and rx_byte[7:1] equals the stored own address, own_hit is 1 after that edge.
- R4: On an own-address match, rw_bit takes rx_byte[0] (1 means the slave transmits, 0 means it receives). On a general-call-only match, rw_bit is 0.
- R5: A first byte equal to 00H sets gc_hit only when configuration bit 0 is 1. With that bit at 0, the byte 00H produces no flag and no irq.
- R6: An own address of 0000000 never produces an own-address match, so a first byte of 00H can only ever be a general call.
- R7: Bytes after the first byte of a transfer never raise irq and leave own_hit, gc_hit and rw_bit unchanged.
- R8: irq is high for exactly the one cycle after the strobe edge of a matching first byte. A non-matching first byte gives no irq.
- R9: The match flags hold until flag_clr or stop_seen is high at an edge, which sets own_hit, gc_hit and rw_bit to 0. A match strobed at that same edge takes priority and sets the flags.
- R10: A repeated START re-arms the check. A new matching first byte replaces the previous flag values, so an own match after a general call shows own_hit=1 and gc_hit=0.
- R11: A byte strobe that follows reset or a STOP without an intervening START is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word to write: own address in 7:1, general-call enable in 0 |
| cfg_rdata | output | 8 | Current configuration word |
| start_seen | input | 1 | One-cycle pulse on START or repeated START |
| stop_seen | input | 1 | One-cycle pulse on STOP |
| byte_done | input | 1 | Strobe: rx_byte holds a complete received byte |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| flag_clr | input | 1 | Host clear of the match flags |
| own_hit | output | 1 | Sticky own-address match flag |
| gc_hit | output | 1 | Sticky general-call match flag |
| rw_bit | output | 1 | Direction bit of the matched address byte |
| irq | output | 1 | One-cycle interrupt request on a match |

## Verification
The bench probes the spots where a recognizer is easy to get wrong. An own address of zero must not turn the byte 01H or 00H into an own match. The byte 00H with general call disabled must be ignored; a design that tests only the byte value would raise a spurious interrupt there. Second and later bytes that happen to equal the address must not re-trigger; a design without a first-byte tracker would fire on every data byte. A clear or STOP at the same edge as a match must leave the flags set; a design with the priority reversed would lose that match.

// File: rtl/slvadr_pkg.sv
package slvadr_pkg;

    // Width of the slave address and of one bus byte
    localparam int unsigned SA_BITS   = 7;
    localparam int unsigned BYTE_BITS = SA_BITS + 1;

    typedef logic [BYTE_BITS-1:0] byte_t;
    typedef logic [SA_BITS-1:0]   saddr_t;

    // The all-zero first byte that addresses every slave at once
    localparam byte_t GC_BYTE = '0;

    // Configuration word: address in the upper bits, enable in bit 0
    typedef struct packed {
        saddr_t addr;
        logic   gc_en;
    } cfg_t;

    // Outcome of comparing one address byte
    typedef struct packed {
        logic own;
        logic gc;
        logic rw;
    } hit_t;

    // Position inside a transfer
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_ADDR = 2'd1,
        FR_DATA = 2'd2
    } frame_e;

    function automatic logic own_match(cfg_t c, byte_t b);
        return (b[BYTE_BITS-1:1] == c.addr) && (c.addr != saddr_t'(0));
    endfunction

    function automatic logic gc_match(cfg_t c, byte_t b);
        return (b == GC_BYTE) && c.gc_en;
    endfunction

endpackage

// File: rtl/slvadr_cfg_reg.sv
module slvadr_cfg_reg
    import slvadr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    output cfg_t  cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_t'(wr_data);
        end
    end

endmodule

// File: rtl/slvadr_frame_track.sv
module slvadr_frame_track
    import slvadr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_pulse,
    input  logic stop_pulse,
    input  logic byte_stb,
    output logic eval
);

    frame_e state_q;
    frame_e state_d;

    // Only the byte completing while the address slot is open is judged
    assign eval = byte_stb && (state_q == FR_ADDR);

    always_comb begin
        state_d = state_q;
        if (start_pulse) begin
            state_d = FR_ADDR;
        end else if (stop_pulse) begin
            state_d = FR_IDLE;
        end else if (byte_stb && state_q == FR_ADDR) begin
            state_d = FR_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/slvadr_cmp.sv
module slvadr_cmp
    import slvadr_pkg::*;
(
    input  cfg_t  cfg,
    input  byte_t rx,
    output hit_t  hit
);

    always_comb begin
        hit.own = own_match(cfg, rx);
        hit.gc  = gc_match(cfg, rx);
        hit.rw  = rx[0];
    end

endmodule

// File: rtl/slvadr_flags.sv
module slvadr_flags
    import slvadr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eval,
    input  hit_t hit,
    input  logic clr,
    output logic own_q,
    output logic gc_q,
    output logic rw_q,
    output logic irq_q
);

    logic any_hit;
    assign any_hit = eval && (hit.own || hit.gc);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= 1'b0;
            gc_q  <= 1'b0;
            rw_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_hit;
            if (any_hit) begin
                own_q <= hit.own;
                gc_q  <= hit.gc;
                rw_q  <= hit.own & hit.rw;
            end else if (clr) begin
                own_q <= 1'b0;
                gc_q  <= 1'b0;
                rw_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/slvadr_match.sv
module slvadr_match
    import slvadr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [BYTE_BITS-1:0] cfg_wdata,
    output logic [BYTE_BITS-1:0] cfg_rdata,
    input  logic                 start_seen,
    input  logic                 stop_seen,
    input  logic                 byte_done,
    input  logic [BYTE_BITS-1:0] rx_byte,
    input  logic                 flag_clr,
    output logic                 own_hit,
    output logic                 gc_hit,
    output logic                 rw_bit,
    output logic                 irq
);

    cfg_t cfg_q;
    hit_t hit;
    logic eval;

    slvadr_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    slvadr_frame_track u_frame (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_seen),
        .stop_pulse  (stop_seen),
        .byte_stb    (byte_done),
        .eval        (eval)
    );

    slvadr_cmp u_cmp (
        .cfg (cfg_q),
        .rx  (rx_byte),
        .hit (hit)
    );

    slvadr_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .eval  (eval),
        .hit   (hit),
        .clr   (flag_clr | stop_seen),
        .own_q (own_hit),
        .gc_q  (gc_hit),
        .rw_q  (rw_bit),
        .irq_q (irq)
    );

    assign cfg_rdata = byte_t'(cfg_q);

endmodule

// File: rtl/slvadr_match_chk.sv
module slvadr_match_chk
    import slvadr_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [BYTE_BITS-1:0] cfg_wdata,
    input logic [BYTE_BITS-1:0] cfg_rdata,
    input logic                 start_seen,
    input logic                 stop_seen,
    input logic                 byte_done,
    input logic [BYTE_BITS-1:0] rx_byte,
    input logic                 flag_clr,
    input logic                 own_hit,
    input logic                 gc_hit,
    input logic                 rw_bit,
    input logic                 irq
);

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    // R3
    own_hit_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && own_hit) |-> ($past(rx_byte[BYTE_BITS-1:1]) == $past(cfg_rdata[BYTE_BITS-1:1])));

    // R6
    own_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && own_hit) |-> ($past(cfg_rdata[BYTE_BITS-1:1]) != '0));

    // R4
    rw_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && own_hit) |-> (rw_bit == $past(rx_byte[0])));

    // R4
    rw_needs_own_chk: assert property (@(posedge clk) disable iff (rst)
        !own_hit |-> !rw_bit);

    // R5
    gc_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && gc_hit) |-> ($past(cfg_rdata[0]) && $past(rx_byte) == '0));

    // R8
    irq_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(byte_done) && (own_hit || gc_hit)));

    // R8
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(own_hit) || $rose(gc_hit)) |-> irq);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((flag_clr || stop_seen) && !byte_done) |=> (!own_hit && !gc_hit && !rw_bit));

endmodule

bind slvadr_match slvadr_match_chk u_chk (.*);

// File: tb/sim_slvadr_match.sv
`timescale 1ns/1ps
module sim_slvadr_match;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       start_seen;
    logic       stop_seen;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic       flag_clr;
    logic       own_hit;
    logic       gc_hit;
    logic       rw_bit;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    slvadr_match u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .flag_clr   (flag_clr),
        .own_hit    (own_hit),
        .gc_hit     (gc_hit),
        .rw_bit     (rw_bit),
        .irq        (irq)
    );

    // {cfg, first byte, own, gc, rw}
    localparam int NVEC = 12;
    localparam logic [18:0] VEC [NVEC] = '{
        {8'hA4, 8'hA4, 3'b100},
        {8'hA4, 8'hA5, 3'b101},
        {8'hA5, 8'hA4, 3'b100},
        {8'hA5, 8'h00, 3'b010},
        {8'hA4, 8'h00, 3'b000},
        {8'hA4, 8'hA6, 3'b000},
        {8'h00, 8'h00, 3'b000},
        {8'h01, 8'h00, 3'b010},
        {8'h01, 8'h01, 3'b000},
        {8'hFE, 8'hFF, 3'b101},
        {8'hFF, 8'hFE, 3'b100},
        {8'h01, 8'h80, 3'b000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        tick(); cfg_we = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start_seen = 1'b1;
        tick(); start_seen = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_seen = 1'b1;
        tick(); stop_seen = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk); flag_clr = 1'b1;
        tick(); flag_clr = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); byte_done = 1'b1; rx_byte = b;
        tick(); byte_done = 1'b0;
    endtask

    task automatic flags_are(input string tag, input logic o, input logic g, input logic r);
        chk({tag, " own_hit"}, own_hit, o);
        chk({tag, " gc_hit"},  gc_hit,  g);
        chk({tag, " rw_bit"},  rw_bit,  r);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; start_seen = 1'b0;
        stop_seen = 1'b0; byte_done = 1'b0; rx_byte = '0; flag_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);
        flags_are("R1", 1'b0, 1'b0, 1'b0);

        // R2 configuration write and readback
        do_cfg(8'h5A);
        chk("R2 cfg_rdata", cfg_rdata, 8'h5A);

        // R11 strobe with no START since reset
        do_cfg(8'hA4);
        do_byte(8'hA4);
        chk("R11 irq", irq, 1'b0);
        flags_are("R11", 1'b0, 1'b0, 1'b0);

        // Table of first-byte cases: R3, R4, R5, R6, R8
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] c;
            logic [7:0] b;
            logic eo, eg, er;
            string tag;
            c  = VEC[i][18:11];
            b  = VEC[i][10:3];
            eo = VEC[i][2];
            eg = VEC[i][1];
            er = VEC[i][0];
            if (c[7:1] == 7'd0)      tag = "R6";
            else if (b == 8'h00)     tag = "R5";
            else if (eo)             tag = "R3/R4";
            else                     tag = "R3";
            do_cfg(c);
            do_clr();
            do_start();
            do_byte(b);
            chk({tag, " R8 irq"}, irq, eo | eg);
            flags_are(tag, eo, eg, er);
            tick();
            chk("R8 irq falls", irq, 1'b0);
            flags_are("R9 hold", eo, eg, er);
        end

        // R7 later bytes ignored
        do_cfg(8'hA4);
        do_clr();
        do_start();
        do_byte(8'h10);
        do_byte(8'hA4);
        chk("R7 irq on data byte", irq, 1'b0);
        flags_are("R7 no match on data byte", 1'b0, 1'b0, 1'b0);
        do_start();
        do_byte(8'hA4);
        flags_are("R7 first byte", 1'b1, 1'b0, 1'b0);
        do_byte(8'hA5);
        chk("R7 irq second byte", irq, 1'b0);
        flags_are("R7 unchanged", 1'b1, 1'b0, 1'b0);

        // R9 persistence, STOP clear, host clear
        repeat (3) tick();
        flags_are("R9 persist", 1'b1, 1'b0, 1'b0);
        do_stop();
        flags_are("R9 stop clears", 1'b0, 1'b0, 1'b0);
        do_start();
        do_byte(8'hA5);
        flags_are("R9 rematch", 1'b1, 1'b0, 1'b1);
        do_clr();
        flags_are("R9 host clear", 1'b0, 1'b0, 1'b0);

        // R9 clear and match at the same edge: match wins
        do_start();
        @(negedge clk); byte_done = 1'b1; rx_byte = 8'hA5; flag_clr = 1'b1;
        tick(); byte_done = 1'b0; flag_clr = 1'b0;
        chk("R9 priority irq", irq, 1'b1);
        flags_are("R9 priority", 1'b1, 1'b0, 1'b1);

        // R11 byte after STOP without START
        do_stop();
        do_byte(8'hA4);
        chk("R11 after stop irq", irq, 1'b0);
        flags_are("R11 after stop", 1'b0, 1'b0, 1'b0);

        // R10 repeated START replaces general call with own match
        do_cfg(8'hA5);
        do_start();
        do_byte(8'h00);
        flags_are("R10 gc first", 1'b0, 1'b1, 1'b0);
        do_start();
        do_byte(8'hA5);
        chk("R10 irq", irq, 1'b1);
        flags_are("R10 own replaces", 1'b1, 1'b0, 1'b1);

        // R1 reset in mid-run
        @(negedge clk); rst = 1'b1;
        tick();
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 cfg after reset", cfg_rdata, 8'h00);
        flags_are("R1 after reset", 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule